// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block is the digital half of a two-channel comparator peripheral. It receives comparator result bits that have already been synchronised elsewhere. It keeps a snapshot of them and raises a per-channel change flag for as long as a live result differs from its snapshot. Software refreshes the snapshot by reading the control register. That read ends the mismatch, after which the flag can be cleared.

A three-bit mode field switches the comparators on or off. When the comparators are switched on, the snapshot is reloaded and mismatches are masked for a configurable settling window. Flags are combined with per-channel enables, a peripheral enable and a global enable. The results drive a processor interrupt request and, while the core sleeps, a wake request.

Top module: `cmp_change_irq`

## Requirements
- R1: After reset the mode field is 000, all flags and enables are 0, `irq_o` and `wake_o` are 0, and both registers read as 0 while all comparator inputs are 0.
- R2: While a channel is enabled and unmasked and its input differs from its snapshot, that channel's flag is 1 from the next clock edge on.
- R3: Writing 1 to a flag bit does not clear it while that channel's mismatch persists.
- R4: A read of the control register (address 0) loads every snapshot from the current inputs at that edge. After that, writing 1 to a flag clears it.
- R5: If an input changes in the same cycle as a control register read, no flag is set for that change, and no flag follows from it later.
- R6: Mode values 000 and 111 switch the comparators off. While they are off, no flag is set whatever the inputs do, and the comparator output bits read as 0.
- R7: A write that moves the mode from off to an on value (anything other than 000 and 111) loads the snapshots from the inputs at that edge. It also masks mismatches for the SETTLE_CYC cycles that follow. A difference present from the write onward sets its flag on edge SETTLE_CYC+1 after the write edge.
- R8: `wake_o` is 1 exactly when `sleep_i` is 1, the peripheral enable is 1, and some channel has both its flag and its enable at 1.
- R9: `irq_o` is 1 exactly when the peripheral enable and the global enable are both 1 and some channel has both its flag and its enable at 1. `sleep_i` has no effect on `irq_o`.
- R10: Change detection and flag setting continue unchanged while `sleep_i` is 1.
- R11: Register map, 8-bit data. Address 0 holds the mode in bits [2:0] (read/write) and the channel 0 and 1 comparator outputs in bits [3] and [4] (read-only). Address 1 holds the flags in bits [1:0] (write 1 to clear, write 0 has no effect), the channel enables in bits [3:2], the peripheral enable in bit 4 and the global enable in bit 5 (all read/write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_i | input | N_CH | Synchronised comparator results |
| sleep_i | input | 1 | Core is sleeping |
| addr_i | input | 1 | Register select: 0 control, 1 interrupt |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the selected register |
| irq_o | output | 1 | Interrupt vector request |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
The bench builds the block with N_CH=2 and SETTLE_CYC=4. The short settling window lets the bench check the masked edges one by one and find the exact edge on which masking ends. With two channels it can check the per-channel enable selection against a flag raised on only one channel, and check that a write-1 clear touches only the flags whose mismatch has ended.

// File: rtl/cmp_change_pkg.sv
package cmp_change_pkg;
  localparam int MODE_W = 3;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_RST_OFF = '0;
  localparam mode_t MODE_ALT_OFF = '1;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_INTR = 1'b1;

  function automatic logic mode_on(mode_t m);
    return (m != MODE_RST_OFF) && (m != MODE_ALT_OFF);
  endfunction
endpackage

// File: rtl/cmp_change_cfg.sv
module cmp_change_cfg
  import cmp_change_pkg::*;
#(
  parameter int N_CH       = 2,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_intr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_t             mode_o,
  output logic              on_o,
  output logic              start_o,
  output logic              settling_o,
  output logic [N_CH-1:0]   clr_o,
  output logic [N_CH-1:0]   ie_o,
  output logic              pie_o,
  output logic              gie_o
);
  localparam int CNT_W   = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam int IE_LSB  = N_CH;
  localparam int PIE_BIT = 2 * N_CH;
  localparam int GIE_BIT = 2 * N_CH + 1;

  mode_t            mode_q;
  logic [N_CH-1:0]  ie_q;
  logic             pie_q, gie_q;
  logic [CNT_W-1:0] cnt_q;
  mode_t            mode_wr;

  assign mode_wr = mode_t'(wdata_i[MODE_W-1:0]);
  assign on_o    = mode_on(mode_q);
  // off -> on transition restarts snapshot and settling window
  assign start_o = wr_ctrl_i && !on_o && mode_on(mode_wr);
  assign settling_o = start_o || (cnt_q != '0);
  assign clr_o   = wr_intr_i ? wdata_i[N_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST_OFF;
      ie_q   <= '0;
      pie_q  <= 1'b0;
      gie_q  <= 1'b0;
    end else begin
      if (wr_ctrl_i) mode_q <= mode_wr;
      if (wr_intr_i) begin
        ie_q  <= wdata_i[IE_LSB +: N_CH];
        pie_q <= wdata_i[PIE_BIT];
        gie_q <= wdata_i[GIE_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_o)       cnt_q <= CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign mode_o = mode_q;
  assign ie_o   = ie_q;
  assign pie_o  = pie_q;
  assign gie_o  = gie_q;

  generate
    if (SETTLE_CYC > 0) begin : g_settle_chk
      // R7: an enabling write opens the masking window
      a_r7_settle_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> (settling_o && on_o));
    end
  endgenerate
endmodule

// File: rtl/cmp_change_lane.sv
module cmp_change_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic active_i,
  input  logic load_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic mis_o,
  output logic flag_o
);
  logic snap_q, flag_q;

  assign mis_o = active_i && (cmp_i != snap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (load_i) snap_q <= cmp_i;
      // read update wins over flag setting in the same cycle
      flag_q <= (flag_q && !clr_i) || (mis_o && !rd_i);
    end
  end

  assign flag_o = flag_q;

  a_r3_clear_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mis_o && !rd_i) |=> flag_q);
  a_r5_read_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !flag_q) |=> !flag_q);
  a_r4_read_syncs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (snap_q == $past(cmp_i)));
endmodule

// File: rtl/cmp_change_req.sv
module cmp_change_req #(
  parameter int N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] flag_i,
  input  logic [N_CH-1:0] ie_i,
  input  logic            pie_i,
  input  logic            gie_i,
  input  logic            sleep_i,
  output logic            irq_o,
  output logic            wake_o
);
  logic pend;

  assign pend   = |(flag_i & ie_i) && pie_i;
  assign wake_o = pend && sleep_i;
  assign irq_o  = pend && gie_i;

  a_r8_wake_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (sleep_i && pie_i && (flag_i != '0)));
  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_i && pie_i && (ie_i != '0)));
endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
  import cmp_change_pkg::*;
#(
  parameter int N_CH       = 2,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   cmp_i,
  input  logic              sleep_i,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int OUT_LSB = MODE_W;

  logic            wr_ctrl, wr_intr, rd_ctrl;
  mode_t           mode;
  logic            on, start, settling, pie, gie;
  logic [N_CH-1:0] clr, ie, flag, mis;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_intr = wr_en_i && (addr_i == ADDR_INTR);
  assign rd_ctrl = rd_en_i && (addr_i == ADDR_CTRL);

  cmp_change_cfg #(.N_CH(N_CH), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) u_cfg (
    .clk_i, .rst_ni,
    .wr_ctrl_i(wr_ctrl), .wr_intr_i(wr_intr), .wdata_i,
    .mode_o(mode), .on_o(on), .start_o(start), .settling_o(settling),
    .clr_o(clr), .ie_o(ie), .pie_o(pie), .gie_o(gie)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    cmp_change_lane u_lane (
      .clk_i, .rst_ni,
      .cmp_i(cmp_i[c]),
      .active_i(on && !settling),
      .load_i(start || rd_ctrl),
      .rd_i(rd_ctrl),
      .clr_i(clr[c]),
      .mis_o(mis[c]),
      .flag_o(flag[c])
    );
  end

  cmp_change_req #(.N_CH(N_CH)) u_req (
    .clk_i, .rst_ni,
    .flag_i(flag), .ie_i(ie), .pie_i(pie), .gie_i(gie), .sleep_i,
    .irq_o, .wake_o
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[MODE_W-1:0]       = mode;
      rdata_o[OUT_LSB +: N_CH]  = cmp_i & {N_CH{on}};
    end else begin
      rdata_o[0 +: N_CH]        = flag;
      rdata_o[N_CH +: N_CH]     = ie;
      rdata_o[2*N_CH]           = pie;
      rdata_o[2*N_CH+1]         = gie;
    end
  end

  a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on |-> (mis == '0));
  a_r6_off_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on && !$past(on) && flag == '0) |=> (flag == '0));
  a_r2_level_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mis != '0) && !rd_ctrl) |=> (flag != '0));
endmodule

// File: tb/cmp_change_irq_test.sv
module cmp_change_irq_test;
  localparam int N_CH = 2;
  localparam int DATA_W = 8;
  localparam int SETTLE_CYC = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_CH-1:0] cmp_i = '0;
  logic sleep_i = 1'b0, addr_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0, rdata_o;
  logic irq_o, wake_o;
  int n_chk = 0, n_bad = 0;
  logic [DATA_W-1:0] rv;

  always #2 clk = ~clk;

  cmp_change_irq #(.N_CH(N_CH), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) uut (
    .clk_i(clk), .rst_ni, .cmp_i, .sleep_i, .addr_i, .wr_en_i, .rd_en_i,
    .wdata_i, .rdata_o, .irq_o, .wake_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [DATA_W-1:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [DATA_W-1:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    tick();
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset();
    rd(1'b0, rv); chk("R1 ctrl", rv, 8'h00);
    rd(1'b1, rv); chk("R1 intr", rv, 8'h00);
    chk("R1 irq", irq_o, 0);
    chk("R1 wake", wake_o, 0);
  endtask

  task automatic t_enable_load();
    cmp_i = 2'b01;
    wr(1'b0, 8'h02);
    repeat (8) tick();
    rd(1'b1, rv); chk("R7 snapshot loaded", rv, 8'h00);
    rd(1'b0, rv); chk("R11 ctrl layout", rv, 8'h0A);
  endtask

  task automatic t_settle();
    wr(1'b0, 8'h00);
    cmp_i = 2'b00;
    wr(1'b0, 8'h03);
    cmp_i = 2'b11;
    repeat (SETTLE_CYC) tick();
    rd(1'b1, rv); chk("R7 masked window", rv, 8'h00);
    rd(1'b1, rv); chk("R2 R7 flag after window", rv, 8'h03);
  endtask

  task automatic t_clear_blocked();
    wr(1'b1, 8'h03);
    rd(1'b1, rv); chk("R3 clear blocked", rv, 8'h03);
  endtask

  task automatic t_read_sync();
    rd(1'b0, rv); chk("R11 outputs readback", rv, 8'h1B);
    wr(1'b1, 8'h03);
    rd(1'b1, rv); chk("R4 clear after read", rv, 8'h00);
  endtask

  task automatic t_read_race();
    cmp_i = 2'b01;
    rd(1'b0, rv); chk("R5 ctrl shows new value", rv, 8'h0B);
    rd(1'b1, rv); chk("R5 no flag on read cycle", rv, 8'h00);
    repeat (3) tick();
    rd(1'b1, rv); chk("R5 no late flag", rv, 8'h00);
  endtask

  task automatic t_level();
    cmp_i = 2'b00;
    tick();
    rd(1'b1, rv); chk("R2 level flag ch0", rv, 8'h01);
  endtask

  task automatic t_gating();
    sleep_i = 1'b1;
    wr(1'b1, 8'h04);
    chk("R8 wake needs pie", wake_o, 0);
    chk("R9 irq needs pie", irq_o, 0);
    wr(1'b1, 8'h14);
    chk("R8 wake set", wake_o, 1);
    chk("R9 irq needs gie", irq_o, 0);
    wr(1'b1, 8'h34);
    chk("R9 irq set", irq_o, 1);
    sleep_i = 1'b0; #1;
    chk("R8 wake needs sleep", wake_o, 0);
    chk("R9 irq ignores sleep", irq_o, 1);
    wr(1'b1, 8'h38);
    chk("R9 enable selects channel", irq_o, 0);
    rd(1'b0, rv);
    wr(1'b1, 8'h03);
    rd(1'b1, rv); chk("R4 cleanup clear", rv, 8'h00);
  endtask

  task automatic t_sleep_detect();
    sleep_i = 1'b1;
    cmp_i = 2'b10;
    tick();
    rd(1'b1, rv); chk("R10 detect in sleep", rv, 8'h02);
    sleep_i = 1'b0;
    rd(1'b0, rv);
    wr(1'b1, 8'h03);
    rd(1'b1, rv); chk("R4 clear ch1", rv, 8'h00);
  endtask

  task automatic t_off_modes();
    wr(1'b0, 8'h07);
    cmp_i = 2'b01;
    repeat (3) tick();
    rd(1'b1, rv); chk("R6 mode 111 no flag", rv, 8'h00);
    rd(1'b0, rv); chk("R6 mode 111 outputs zero", rv, 8'h07);
    wr(1'b0, 8'h00);
    cmp_i = 2'b11;
    repeat (3) tick();
    rd(1'b1, rv); chk("R6 mode 000 no flag", rv, 8'h00);
    rd(1'b0, rv); chk("R6 mode 000 outputs zero", rv, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick();
    t_reset();
    t_enable_load();
    t_settle();
    t_clear_blocked();
    t_read_sync();
    t_read_race();
    t_level();
    t_gating();
    t_sleep_detect();
    t_off_modes();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule